// File: doc/BRIEF.md
# SPI Flash Busy-Wait Poller

This block waits in hardware for a serial NOR flash to finish an erase or program operation. Software or a sequencer pulses `start` and gives the device's manufacturer ID, its capacity in bytes and a timeout in system clock cycles. The block then takes the SPI bus in mode 0 with a single data line. It lowers chip select once and sends one status-read opcode. It then clocks in status bytes back to back, without releasing chip select, until the chosen status bit shows the device is ready or the time limit runs out.

Two status registers are supported, and the choice is made at run time from the ID and size. Each register has its own opcode, its own bit and its own ready polarity. When polling ends, chip select is released and `done` pulses for one cycle. `timed_out` then tells failure from success, and `last_status` holds the final byte that was captured. The block makes its decision from that final byte. A ready byte therefore counts as success even if the limit has also been reached.

Top module: `spi_busy_poll`

## Requirements
- R1: After reset, `spi_cs_n` is 1, `spi_sck` is 0, and `busy`, `done` and `timed_out` are 0. `last_status` is 8'h00.
- R2: The alternate register is used only when `mfr_id` is 8'h20 and `dev_size` is at least 32'h0400_0000. Every other combination uses the standard register.
- R3: In standard mode the opcode sent is 8'h05 and the device is ready when bit 0 of the status byte is 0.
- R4: In alternate mode the opcode sent is 8'h70 and the device is ready when bit 7 of the status byte is 1.
- R5: Each poll asserts chip select exactly once and sends the opcode exactly once. All status bytes follow the opcode inside that one assertion. MOSI is 0 on every rising SCK edge during the status bytes.
- R6: SPI mode 0 is used. SCK idles low, bits go out MSB first, and MISO is sampled on the rising edge of SCK. SCK half-period is `CLK_DIV` system cycles.
- R7: The poll stops after the first status byte that shows ready, so the number of status bytes read is the index of the first ready byte plus one.
- R8: A poll that sees no ready byte stops at the first byte boundary after `tmo_limit` cycles have elapsed. It then reports `timed_out` = 1.
- R9: If the final captured byte shows ready, `timed_out` is 0, even when the limit had already expired (for example, `tmo_limit` = 1 with the first byte ready).
- R10: `done` is high for exactly one cycle. That cycle is the one in which `spi_cs_n` returns to 1, and in it `busy` is 0. `busy` is 1 from the cycle after `start` until then.
- R11: `last_status` equals the last status byte clocked in during the poll and holds that value until the next poll.
- R12: A `start` pulse while `busy` is 1 is ignored. The opcode, the mode and the single chip-select assertion of the running poll are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a poll |
| mfr_id | input | 8 | Manufacturer ID byte of the device |
| dev_size | input | SIZE_W | Device capacity in bytes |
| tmo_limit | input | LIMIT_W | Timeout in system clock cycles |
| spi_miso | input | 1 | Serial data from the flash |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_sck | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| busy | output | 1 | Poll in progress |
| done | output | 1 | One-cycle pulse when polling ends |
| timed_out | output | 1 | Last poll ended without a ready status |
| last_status | output | 8 | Last status byte captured |

## Verification
The assertions assume that `start` comes from a synchronous source and that `mfr_id`, `dev_size` and `tmo_limit` are valid in the cycle `start` is high. They also assume the flash drives MISO only on falling SCK edges while selected. The bench's flash model changes MISO only on falling SCK edges after the opcode. It drives the start inputs at negative clock edges for one cycle. Random status bytes always keep the polled bit at its busy value until the chosen ready index, so the expected byte count can be computed exactly.

// File: rtl/spi_poll_pkg.sv
package spi_poll_pkg;

  typedef enum logic [1:0] {
    PS_IDLE,
    PS_OPCODE,
    PS_POLL
  } poll_state_t;

  typedef struct packed {
    logic [7:0] opcode;
    logic [7:0] mask;
    logic       ready_when_set;
  } poll_cfg_t;

  localparam logic [7:0]  OP_STD       = 8'h05;
  localparam logic [7:0]  MASK_STD     = 8'h01;
  localparam logic [7:0]  OP_ALT       = 8'h70;
  localparam logic [7:0]  MASK_ALT     = 8'h80;
  localparam logic [7:0]  ALT_MFR      = 8'h20;
  localparam logic [31:0] ALT_MIN_SIZE = 32'h0400_0000;

  function automatic logic status_ready(input logic [7:0] st, input poll_cfg_t cfg);
    return ((st & cfg.mask) != 8'h00) == cfg.ready_when_set;
  endfunction

endpackage

// File: rtl/poll_mode_sel.sv
module poll_mode_sel
  import spi_poll_pkg::*;
#(
  parameter int SIZE_W = 32
) (
  input  logic [7:0]        mfr_id,
  input  logic [SIZE_W-1:0] dev_size,
  output poll_cfg_t         cfg
);
  localparam logic [SIZE_W-1:0] MIN_SIZE = SIZE_W'(ALT_MIN_SIZE);

  logic use_alt;

  always_comb begin
    use_alt = (mfr_id == ALT_MFR) && (dev_size >= MIN_SIZE);
    if (use_alt) begin
      cfg.opcode         = OP_ALT;
      cfg.mask           = MASK_ALT;
      cfg.ready_when_set = 1'b1;
    end else begin
      cfg.opcode         = OP_STD;
      cfg.mask           = MASK_STD;
      cfg.ready_when_set = 1'b0;
    end
  end
endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       go,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       byte_done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = $clog2(CLK_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);

  logic             active;
  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       tx_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      div_cnt   <= '0;
      bit_cnt   <= '0;
      tx_sh     <= '0;
      rx_byte   <= '0;
      sck       <= 1'b0;
      mosi      <= 1'b0;
      byte_done <= 1'b0;
    end else begin
      byte_done <= 1'b0;
      if (!active) begin
        if (go) begin
          active  <= 1'b1;
          div_cnt <= '0;
          bit_cnt <= '0;
          tx_sh   <= tx_byte;
          mosi    <= tx_byte[7];
          sck     <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sck) begin
          sck     <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sck <= 1'b0;
          if (bit_cnt == 3'd7) begin
            active    <= 1'b0;
            byte_done <= 1'b1;
            mosi      <= 1'b0;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            tx_sh   <= {tx_sh[6:0], 1'b0};
            mosi    <= tx_sh[6];
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
  parameter int LIMIT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clear,
  input  logic               run,
  input  logic [LIMIT_W-1:0] limit,
  output logic               expired
);
  localparam logic [LIMIT_W-1:0] CNT_MAX = '1;

  logic [LIMIT_W-1:0] cnt;
  logic [LIMIT_W-1:0] limit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      limit_q <= '0;
      expired <= 1'b0;
    end else if (clear) begin
      cnt     <= '0;
      limit_q <= limit;
      expired <= 1'b0;
    end else begin
      if (run && cnt != CNT_MAX) cnt <= cnt + LIMIT_W'(1);
      expired <= run && (cnt >= limit_q);
    end
  end
endmodule

// File: rtl/spi_busy_poll.sv
module spi_busy_poll
  import spi_poll_pkg::*;
#(
  parameter int CLK_DIV = 2,
  parameter int LIMIT_W = 32,
  parameter int SIZE_W  = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [7:0]         mfr_id,
  input  logic [SIZE_W-1:0]  dev_size,
  input  logic [LIMIT_W-1:0] tmo_limit,
  input  logic               spi_miso,
  output logic               spi_cs_n,
  output logic               spi_sck,
  output logic               spi_mosi,
  output logic               busy,
  output logic               done,
  output logic               timed_out,
  output logic [7:0]         last_status
);
  poll_state_t state;
  poll_cfg_t   cfg_now, cfg_q;
  logic        go_q;
  logic [7:0]  tx_q;
  logic        byte_done;
  logic [7:0]  rx_byte;
  logic        tmr_expired;
  logic        byte_ready;
  logic        launch;

  assign launch     = (state == PS_IDLE) && start;
  assign byte_ready = status_ready(rx_byte, cfg_q);

  poll_mode_sel #(.SIZE_W(SIZE_W)) u_sel (
    .mfr_id   (mfr_id),
    .dev_size (dev_size),
    .cfg      (cfg_now)
  );

  spi_byte_engine #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .go        (go_q),
    .tx_byte   (tx_q),
    .miso      (spi_miso),
    .sck       (spi_sck),
    .mosi      (spi_mosi),
    .byte_done (byte_done),
    .rx_byte   (rx_byte)
  );

  poll_timer #(.LIMIT_W(LIMIT_W)) u_tmr (
    .clk     (clk),
    .rst     (rst),
    .clear   (launch),
    .run     (busy),
    .limit   (tmo_limit),
    .expired (tmr_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= PS_IDLE;
      cfg_q       <= '0;
      go_q        <= 1'b0;
      tx_q        <= '0;
      spi_cs_n    <= 1'b1;
      busy        <= 1'b0;
      done        <= 1'b0;
      timed_out   <= 1'b0;
      last_status <= '0;
    end else begin
      go_q <= 1'b0;
      done <= 1'b0;
      case (state)
        PS_IDLE: begin
          if (start) begin
            cfg_q     <= cfg_now;
            tx_q      <= cfg_now.opcode;
            go_q      <= 1'b1;
            spi_cs_n  <= 1'b0;
            busy      <= 1'b1;
            timed_out <= 1'b0;
            state     <= PS_OPCODE;
          end
        end
        PS_OPCODE: begin
          if (byte_done) begin
            tx_q  <= 8'h00;
            go_q  <= 1'b1;
            state <= PS_POLL;
          end
        end
        PS_POLL: begin
          if (byte_done) begin
            last_status <= rx_byte;
            if (byte_ready || tmr_expired) begin
              spi_cs_n  <= 1'b1;
              busy      <= 1'b0;
              done      <= 1'b1;
              timed_out <= !byte_ready;
              state     <= PS_IDLE;
            end else begin
              go_q <= 1'b1;
            end
          end
        end
        default: state <= PS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/spi_busy_poll_chk.sv
module spi_busy_poll_chk
  import spi_poll_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       busy,
  input logic       done,
  input logic       timed_out,
  input logic [7:0] last_status,
  input poll_cfg_t  cfg_q
);
  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
    spi_cs_n |-> !spi_sck); // R6

  AST_CS_HELD: assert property (@(posedge clk) disable iff (rst)
    busy |-> !spi_cs_n); // R5

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    $rose(spi_cs_n) |-> (done && !busy)); // R10

  AST_TMO_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    $rose(timed_out) |-> done); // R8

  AST_SUCCESS_READY: assert property (@(posedge clk) disable iff (rst)
    (done && !timed_out) |-> status_ready(last_status, cfg_q)); // R9

  AST_STATUS_STABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !done) |-> $stable(last_status)); // R11
endmodule

bind spi_busy_poll spi_busy_poll_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .spi_cs_n    (spi_cs_n),
  .spi_sck     (spi_sck),
  .busy        (busy),
  .done        (done),
  .timed_out   (timed_out),
  .last_status (last_status),
  .cfg_q       (cfg_q)
);

// File: tb/sim_spi_busy_poll.sv
module sim_spi_busy_poll;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  mfr_id = 8'h00;
  logic [31:0] dev_size = 32'h0;
  logic [31:0] tmo_limit = 32'h0;
  logic        spi_miso = 1'b0;
  logic        spi_cs_n, spi_sck, spi_mosi, busy, done, timed_out;
  logic [7:0]  last_status;

  int checks = 0;
  int failures = 0;

  int m_ready_idx = 0;
  logic [7:0] m_busy = 8'h00;
  logic [7:0] m_ready = 8'h00;
  int rise_cnt = 0;
  int fall_cnt = 0;
  int mosi_err = 0;
  int cs_falls = 0;
  logic [7:0] opc_seen = 8'h00;

  always #2 clk = ~clk;

  spi_busy_poll u0 (
    .clk(clk), .rst(rst), .start(start), .mfr_id(mfr_id), .dev_size(dev_size),
    .tmo_limit(tmo_limit), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .busy(busy), .done(done),
    .timed_out(timed_out), .last_status(last_status)
  );

  function automatic logic [7:0] status_of(input int idx);
    return (idx < m_ready_idx) ? m_busy : m_ready;
  endfunction

  function automatic logic exp_alt(input logic [7:0] id, input logic [31:0] sz);
    return (id == 8'h20) && (sz >= 32'h0400_0000);
  endfunction

  // flash model: mode 0, drives on falling SCK
  always @(negedge spi_cs_n) begin
    rise_cnt = 0; fall_cnt = 0; mosi_err = 0; opc_seen = 8'h00;
    spi_miso = 1'b0; cs_falls = cs_falls + 1;
  end
  always @(posedge spi_sck) if (!spi_cs_n) begin
    if (rise_cnt < 8) opc_seen = {opc_seen[6:0], spi_mosi};
    else if (spi_mosi) mosi_err = mosi_err + 1;
    rise_cnt = rise_cnt + 1;
  end
  always @(negedge spi_sck) if (!spi_cs_n) begin
    logic [7:0] b;
    fall_cnt = fall_cnt + 1;
    if (fall_cnt >= 8) begin
      b = status_of((fall_cnt - 8) / 8);
      spi_miso = b[7 - ((fall_cnt - 8) % 8)];
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] id, input logic [31:0] sz, input logic [31:0] lim);
    @(negedge clk);
    mfr_id = id; dev_size = sz; tmo_limit = lim; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int ok);
    ok = 0;
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (done) begin ok = 1; break; end
    end
  endtask

  task automatic run_poll(input string req, input logic [7:0] id, input logic [31:0] sz,
                          input logic [31:0] lim, input int ridx,
                          input logic [7:0] bb, input logic [7:0] rb, input logic exp_tmo);
    int ok;
    int falls0;
    int nbytes;
    m_ready_idx = ridx; m_busy = bb; m_ready = rb;
    falls0 = cs_falls;
    pulse_start(id, sz, lim);
    check(req, "busy after start", int'(busy), 1);
    wait_done(ok);
    check(req, "done seen", ok, 1);
    check("R10", "busy low at done", int'(busy), 0);
    check("R10", "cs released at done", int'(spi_cs_n), 1);
    check("R5", "single cs assertion", cs_falls - falls0, 1);
    check(exp_alt(id, sz) ? "R4" : "R3", "opcode", int'(opc_seen),
          exp_alt(id, sz) ? 8'h70 : 8'h05);
    check("R2", "mode from id/size", int'(opc_seen == 8'h70), int'(exp_alt(id, sz)));
    check("R5", "mosi low while reading", mosi_err, 0);
    check("R6", "whole bytes clocked", rise_cnt % 8, 0);
    nbytes = (rise_cnt - 8) / 8;
    check(exp_tmo ? "R8" : "R9", "timed_out", int'(timed_out), int'(exp_tmo));
    if (!exp_tmo) begin
      check("R7", "status byte count", nbytes, ridx + 1);
      check("R11", "last_status", int'(last_status), int'(rb));
    end else begin
      check("R8", "bytes before timeout", int'(nbytes >= 2 && nbytes <= 40), 1);
      check("R11", "last_status busy byte", int'(last_status), int'(bb));
    end
    @(negedge clk);
    check("R10", "done one cycle", int'(done), 0);
    check("R11", "last_status held", int'(last_status), exp_tmo ? int'(bb) : int'(rb));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] bb, rb, id;
    logic [31:0] sz;
    int ok;
    int falls0;
    void'($urandom(32'h5eed_0042));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "cs_n", int'(spi_cs_n), 1);
    check("R1", "sck", int'(spi_sck), 0);
    check("R1", "busy/done/tmo", int'({busy, done, timed_out}), 0);
    check("R1", "last_status", int'(last_status), 0);

    // directed: standard mode, size just below threshold
    run_poll("R3", 8'h20, 32'h03FF_FFFF, 32'd100000, 2, 8'hA5, 8'h5A, 1'b0);
    // alternate mode at exact threshold
    run_poll("R4", 8'h20, 32'h0400_0000, 32'd100000, 3, 8'h7F, 8'h80, 1'b0);
    // other manufacturer with big size stays standard
    run_poll("R2", 8'h21, 32'h1000_0000, 32'd100000, 1, 8'hFF, 8'hFE, 1'b0);
    // timeout in standard mode, never ready
    run_poll("R8", 8'hEF, 32'h0100_0000, 32'd300, 1000, 8'h03, 8'h00, 1'b1);
    // timeout in alternate mode
    run_poll("R8", 8'h20, 32'h0800_0000, 32'd300, 1000, 8'h01, 8'h80, 1'b1);
    // limit already expired but first byte ready: success
    run_poll("R9", 8'h20, 32'h0800_0000, 32'd1, 0, 8'h00, 8'h81, 1'b0);
    run_poll("R9", 8'h01, 32'h0000_1000, 32'd0, 0, 8'h01, 8'hFE, 1'b0);

    // R12: start while busy is ignored
    m_ready_idx = 1000; m_busy = 8'h00; m_ready = 8'h80;
    falls0 = cs_falls;
    pulse_start(8'h20, 32'h0400_0000, 32'd400);
    repeat (60) @(negedge clk);
    pulse_start(8'h01, 32'h0000_0100, 32'd10);
    wait_done(ok);
    check("R12", "done seen", ok, 1);
    check("R12", "cs asserted once", cs_falls - falls0, 1);
    check("R12", "opcode unchanged", int'(opc_seen), 8'h70);
    check("R12", "timed out per first limit", int'(timed_out), 1);
    check("R12", "poll ran past second limit", int'(rise_cnt >= 8 + 8 * 8), 1);
    repeat (3) @(negedge clk);

    // random mix
    for (int n = 0; n < 16; n++) begin
      case ($urandom % 3)
        0: begin id = 8'h20; sz = 32'h0400_0000 + ($urandom % 32'h0400_0000); end
        1: begin id = 8'h20; sz = $urandom % 32'h0400_0000; end
        default: begin id = 8'($urandom); sz = $urandom; end
      endcase
      if (exp_alt(id, sz)) begin
        bb = 8'($urandom) & 8'h7F; rb = 8'($urandom) | 8'h80;
      end else begin
        bb = 8'($urandom) | 8'h01; rb = 8'($urandom) & 8'hFE;
      end
      run_poll("R7", id, sz, 32'd100000, int'($urandom % 5), bb, rb, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule